// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps the message table and the pending-bit array of a PCI function that signals interrupts through MSI-X. Software reaches both through a dword-only register port. The table sits at the bottom of a 4 KB window. Each vector owns a 16-byte slot holding the message address (two words), the message data and a control word. The pending array is a read-only bitmap that starts halfway up the window.

The function logic raises interrupts as one-cycle pulses on a per-vector request bus. It also says which vectors it actually uses. A request on a vector that may deliver becomes a 64-bit-address, 32-bit-data memory-write request on a valid/ready output. A request on a vector that is masked, either by its own mask bit or by the function-wide mask-all bit, is latched as pending. That request is replayed on its own once the vector's effective mask clears. When the output is stalled, requests wait internally and leave in ascending vector order.

Top module: `msix_vec_ctrl`

## Requirements
- R1: Vector v occupies bytes 16*v to 16*v+15 of the window: word 0 is the low address, word 1 the high address, word 2 the data, word 3 the control word. Words 0 to 2 read back exactly what was written.
- R2: Only bit 0 of the control word is stored; it is the vector's own mask bit. All other control bits read as zero.
- R3: A vector is effectively masked when the mask-all bit is 1 or its own mask bit is 1.
- R4: The pending array is read at byte offset 0x800. Bit v of that dword is the pending bit of vector v (byte v/8, bit v mod 8). Writes to this region have no effect.
- R5: A request on an effectively masked vector sets its pending bit and produces no message.
- R6: When a vector with its pending bit set becomes unmasked, whether through a table write or by clearing mask-all, the pending bit clears and the message is sent.
- R7: A message carries address {high word, low word} and the data word of its vector.
- R8: A request is dropped entirely when the vector number is at or above `num_entries` or when the vector's `vec_used` bit is 0.
- R9: Reset and a `bring_up` pulse zero the table, set every mask bit, and clear the enable bit, the mask-all bit, all pending state and the output.
- R10: An access whose byte enables are not all ones is rejected. It raises `reg_err` with the ack, writes nothing and reads zero. Address bits 1:0 are ignored.
- R11: Dropping a vector's `vec_used` bit clears its pending bit, so that request is never sent.
- R12: While `msg_valid` is high and `msg_ready` is low, the message stays unchanged. Waiting requests are sent lowest vector first.
- R13: A register access is acknowledged on the edge after the one that samples it. An unmasked request shows on `msg_valid` two edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bring_up | input | 1 | Pulse that returns the block to its reset contents |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address in the 4 KB window |
| reg_be | input | 4 | Byte enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with the ack |
| reg_ack | output | 1 | Access acknowledge |
| reg_err | output | 1 | Access rejected (not a full dword) |
| ctl_wr | input | 1 | Load the function control bits |
| ctl_enable_d | input | 1 | New enable bit |
| ctl_maskall_d | input | 1 | New mask-all bit |
| fn_enable | output | 1 | Current enable bit |
| fn_maskall | output | 1 | Current mask-all bit |
| num_entries | input | 6 | Configured number of vectors |
| vec_used | input | NUM_VEC | Per-vector in-use flags |
| irq_pulse | input | NUM_VEC | Per-vector request pulses |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message payload |

## Verification
A register read is checked on the step after the edge that acks it, so ack, error and data are sampled one edge after the request. The two-edge request-to-output path is checked explicitly: the output is still idle one step after the pulse and valid one step later. Replays after an unmask take one more edge for the table write; the scoreboard does not depend on that exact delay, but it requires the replayed messages in issue order, and its order is what proves the ascending drain after a stall. All inputs change one time unit after a rising edge and the monitor samples on the falling edge, so no sample lands on the edge that changes it.

// File: rtl/msix_pkg.sv
package msix_pkg;
   localparam int MAX_VEC   = 32;
   localparam int CNT_W     = 6;
   localparam int SLOT_B    = 16;

   typedef enum logic [1:0] {
      WSEL_ADDR_LO = 2'd0,
      WSEL_ADDR_HI = 2'd1,
      WSEL_DATA    = 2'd2,
      WSEL_CTRL    = 2'd3
   } word_sel_e;

   typedef struct packed {
      logic [31:0] addr_lo;
      logic [31:0] addr_hi;
      logic [31:0] data;
      logic        mask;
   } slot_t;
endpackage

// File: rtl/msix_regs.sv
module msix_regs
   import msix_pkg::*;
#(
   parameter int NUM_VEC = 8,
   parameter int AW      = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bring_up,
   input  logic                 reg_req,
   input  logic                 reg_we,
   input  logic [AW-1:0]        reg_addr,
   input  logic [3:0]           reg_be,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   output logic                 reg_ack,
   output logic                 reg_err,
   input  logic                 ctl_wr,
   input  logic                 ctl_enable_d,
   input  logic                 ctl_maskall_d,
   output logic                 fn_enable,
   output logic                 fn_maskall,
   input  logic [NUM_VEC-1:0]   pba,
   output slot_t [NUM_VEC-1:0]  slots,
   output logic [NUM_VEC-1:0]   eff_mask
);
   localparam int IDX_W = AW - 5;
   localparam int PDW_W = AW - 3;

   logic              full_dw;
   logic              in_pba;
   logic [IDX_W-1:0]  slot_idx;
   logic [PDW_W-1:0]  pba_dw;
   word_sel_e         wsel;
   logic              wr_hit;
   logic [31:0]       rd_val;
   logic [31:0]       pba32;
   logic [NUM_VEC-1:0] own_mask;

   generate
      if (NUM_VEC < 1 || NUM_VEC > MAX_VEC) begin : g_bad_vec
         $error("NUM_VEC must be 1..32");
      end
      if (AW != 12) begin : g_bad_aw
         $error("window is 4 KB, AW must be 12");
      end
   endgenerate

   assign full_dw  = (reg_be == 4'hF);
   assign in_pba   = reg_addr[AW-1];
   assign slot_idx = reg_addr[AW-2:4];
   assign pba_dw   = reg_addr[AW-2:2];
   assign wsel     = word_sel_e'(reg_addr[3:2]);
   assign wr_hit   = reg_req && reg_we && full_dw && !in_pba;

   generate
      for (genvar v = 0; v < NUM_VEC; v++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n || bring_up) begin
               slots[v].addr_lo <= '0;
               slots[v].addr_hi <= '0;
               slots[v].data    <= '0;
               slots[v].mask    <= 1'b1;
            end else if (wr_hit && slot_idx == IDX_W'(v)) begin
               case (wsel)
                  WSEL_ADDR_LO: slots[v].addr_lo <= reg_wdata;
                  WSEL_ADDR_HI: slots[v].addr_hi <= reg_wdata;
                  WSEL_DATA:    slots[v].data    <= reg_wdata;
                  default:      slots[v].mask    <= reg_wdata[0];
               endcase
            end
         end
         assign own_mask[v] = slots[v].mask;
      end
   endgenerate

   assign eff_mask = own_mask | {NUM_VEC{fn_maskall}};

   always_ff @(posedge clk) begin
      if (!rst_n || bring_up) begin
         fn_enable  <= 1'b0;
         fn_maskall <= 1'b0;
      end else if (ctl_wr) begin
         fn_enable  <= ctl_enable_d;
         fn_maskall <= ctl_maskall_d;
      end
   end

   always_comb begin
      pba32 = '0;
      pba32[NUM_VEC-1:0] = pba;
   end

   always_comb begin
      rd_val = '0;
      if (in_pba) begin
         if (pba_dw == '0) rd_val = pba32;
      end else begin
         for (int v = 0; v < NUM_VEC; v++) begin
            if (slot_idx == IDX_W'(v)) begin
               case (wsel)
                  WSEL_ADDR_LO: rd_val = slots[v].addr_lo;
                  WSEL_ADDR_HI: rd_val = slots[v].addr_hi;
                  WSEL_DATA:    rd_val = slots[v].data;
                  default:      rd_val = {31'd0, slots[v].mask};
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_ack   <= 1'b0;
         reg_err   <= 1'b0;
         reg_rdata <= '0;
      end else begin
         reg_ack   <= reg_req;
         reg_err   <= reg_req && !full_dw;
         reg_rdata <= (reg_req && !reg_we && full_dw) ? rd_val : '0;
      end
   end

   AST_NARROW_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req && reg_be != 4'hF |=> reg_ack && reg_err && reg_rdata == '0); // R10
   AST_BRINGUP_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      bring_up |=> (&own_mask) && !fn_maskall && !fn_enable); // R9
   AST_MASKALL_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
      fn_maskall |-> (&eff_mask)); // R3
endmodule

// File: rtl/msix_pend.sv
module msix_pend
   import msix_pkg::*;
#(
   parameter int NUM_VEC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bring_up,
   input  logic [NUM_VEC-1:0] irq_pulse,
   input  logic [NUM_VEC-1:0] vec_used,
   input  logic [CNT_W-1:0]   num_entries,
   input  logic [NUM_VEC-1:0] eff_mask,
   input  logic [NUM_VEC-1:0] take,
   output logic [NUM_VEC-1:0] pba,
   output logic [NUM_VEC-1:0] cand
);
   logic [NUM_VEC-1:0] fire;
   logic [NUM_VEC-1:0] ok;

   generate
      for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
         assign ok[v] = vec_used[v] && (CNT_W'(v) < num_entries);

         always_ff @(posedge clk) begin
            if (!rst_n || bring_up) begin
               pba[v]  <= 1'b0;
               fire[v] <= 1'b0;
            end else begin
               pba[v]  <= ok[v] && eff_mask[v] && (pba[v] || irq_pulse[v] || fire[v]);
               fire[v] <= ok[v] && !eff_mask[v] &&
                          ((fire[v] && !take[v]) || irq_pulse[v] || pba[v]);
            end
         end

         assign cand[v] = fire[v] && ok[v] && !eff_mask[v];

         AST_PBA_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
            pba[v] && !eff_mask[v] |=> !pba[v]); // R6
         AST_UNUSED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            !ok[v] |=> !pba[v] && !cand[v]); // R11
         AST_MASKED_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
            irq_pulse[v] && ok[v] && eff_mask[v] && !bring_up |=> pba[v] || !eff_mask[v]); // R5
      end
   endgenerate
endmodule

// File: rtl/msix_out.sv
module msix_out
   import msix_pkg::*;
#(
   parameter int NUM_VEC = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bring_up,
   input  logic [NUM_VEC-1:0]  cand,
   input  slot_t [NUM_VEC-1:0] slots,
   input  logic                msg_ready,
   output logic [NUM_VEC-1:0]  take,
   output logic                msg_valid,
   output logic [63:0]         msg_addr,
   output logic [31:0]         msg_data
);
   logic        can_load;
   logic [63:0] sel_addr;
   logic [31:0] sel_data;

   assign can_load = !msg_valid || msg_ready;
   assign take     = can_load ? (cand & (~cand + NUM_VEC'(1))) : '0;

   always_comb begin
      sel_addr = '0;
      sel_data = '0;
      for (int v = 0; v < NUM_VEC; v++) begin
         if (take[v]) begin
            sel_addr = {slots[v].addr_hi, slots[v].addr_lo};
            sel_data = slots[v].data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || bring_up) begin
         msg_valid <= 1'b0;
         msg_addr  <= '0;
         msg_data  <= '0;
      end else if (can_load) begin
         msg_valid <= |cand;
         msg_addr  <= sel_addr;
         msg_data  <= sel_data;
      end
   end

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take)); // R12
   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready && !bring_up |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R12
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
   import msix_pkg::*;
#(
   parameter int NUM_VEC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bring_up,
   input  logic               reg_req,
   input  logic               reg_we,
   input  logic [11:0]        reg_addr,
   input  logic [3:0]         reg_be,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               reg_ack,
   output logic               reg_err,
   input  logic               ctl_wr,
   input  logic               ctl_enable_d,
   input  logic               ctl_maskall_d,
   output logic               fn_enable,
   output logic               fn_maskall,
   input  logic [5:0]         num_entries,
   input  logic [NUM_VEC-1:0] vec_used,
   input  logic [NUM_VEC-1:0] irq_pulse,
   output logic               msg_valid,
   input  logic               msg_ready,
   output logic [63:0]        msg_addr,
   output logic [31:0]        msg_data
);
   slot_t [NUM_VEC-1:0] slots;
   logic [NUM_VEC-1:0]  eff_mask;
   logic [NUM_VEC-1:0]  pba;
   logic [NUM_VEC-1:0]  cand;
   logic [NUM_VEC-1:0]  take;

   msix_regs #(.NUM_VEC(NUM_VEC), .AW(12)) u_regs (
      .clk(clk), .rst_n(rst_n), .bring_up(bring_up),
      .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack), .reg_err(reg_err),
      .ctl_wr(ctl_wr), .ctl_enable_d(ctl_enable_d), .ctl_maskall_d(ctl_maskall_d),
      .fn_enable(fn_enable), .fn_maskall(fn_maskall),
      .pba(pba), .slots(slots), .eff_mask(eff_mask)
   );

   msix_pend #(.NUM_VEC(NUM_VEC)) u_pend (
      .clk(clk), .rst_n(rst_n), .bring_up(bring_up),
      .irq_pulse(irq_pulse), .vec_used(vec_used), .num_entries(num_entries),
      .eff_mask(eff_mask), .take(take), .pba(pba), .cand(cand)
   );

   msix_out #(.NUM_VEC(NUM_VEC)) u_out (
      .clk(clk), .rst_n(rst_n), .bring_up(bring_up),
      .cand(cand), .slots(slots), .msg_ready(msg_ready), .take(take),
      .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
   );

   AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req |=> reg_ack); // R13
endmodule

// File: tb/sim_msix_vec_ctrl.sv
module sim_msix_vec_ctrl;
   localparam int CLK_PER = 10;
   localparam int NV      = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bring_up = 1'b0;
   logic reg_req = 1'b0, reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [3:0]  reg_be = 4'hF;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic reg_ack, reg_err;
   logic ctl_wr = 1'b0, ctl_enable_d = 1'b0, ctl_maskall_d = 1'b0;
   logic fn_enable, fn_maskall;
   logic [5:0] num_entries = 6'd8;
   logic [NV-1:0] vec_used = '1;
   logic [NV-1:0] irq_pulse = '0;
   logic msg_valid, msg_ready = 1'b1;
   logic [63:0] msg_addr;
   logic [31:0] msg_data;

   int checks = 0;
   int errors = 0;
   logic [95:0] expq[$];

   always #(CLK_PER/2) clk = ~clk;

   msix_vec_ctrl #(.NUM_VEC(NV)) u0 (
      .clk(clk), .rst_n(rst_n), .bring_up(bring_up),
      .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack), .reg_err(reg_err),
      .ctl_wr(ctl_wr), .ctl_enable_d(ctl_enable_d), .ctl_maskall_d(ctl_maskall_d),
      .fn_enable(fn_enable), .fn_maskall(fn_maskall),
      .num_entries(num_entries), .vec_used(vec_used), .irq_pulse(irq_pulse),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
   );

   task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [11:0] slot_a(input int v, input int w);
      return 12'(v * 16 + w * 4);
   endfunction

   function automatic logic [31:0] lo_of(input int v); return 32'h1000_0000 + 32'(v * 16); endfunction
   function automatic logic [31:0] hi_of(input int v); return 32'h0000_A000 + 32'(v); endfunction
   function automatic logic [31:0] dat_of(input int v); return 32'h0000_00D0 + 32'(v); endfunction

   task automatic push_exp(input int v);
      expq.push_back({hi_of(v), lo_of(v), dat_of(v)});
   endtask

   task automatic acc(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input logic [3:0] be, output logic [31:0] rd, output logic er);
      step();
      reg_req = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d; reg_be = be;
      step();
      reg_req = 1'b0; reg_we = 1'b0; reg_be = 4'hF;
      rd = reg_rdata; er = reg_err;
      if (reg_ack !== 1'b1) chk("R13 ack", {95'd0, reg_ack}, 96'd1);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      logic [31:0] rd; logic er;
      acc(1'b1, a, d, 4'hF, rd, er);
   endtask

   task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] rd; logic er;
      acc(1'b0, a, 32'd0, 4'hF, rd, er);
      chk(tag, {64'd0, rd}, {64'd0, exp});
   endtask

   task automatic ctl(input logic en, input logic ma);
      step();
      ctl_wr = 1'b1; ctl_enable_d = en; ctl_maskall_d = ma;
      step();
      ctl_wr = 1'b0;
   endtask

   task automatic pulse(input logic [NV-1:0] p);
      step();
      irq_pulse = p;
      step();
      irq_pulse = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   // scoreboard monitor: a transfer completes at the rising edge after this sample
   always @(negedge clk) begin
      if (rst_n && msg_valid && msg_ready) begin
         if (expq.size() == 0) begin
            chk("R7 unexpected message", {msg_addr, msg_data}, 96'd0);
         end else begin
            chk("R7 R12 message", {msg_addr, msg_data}, expq.pop_front());
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] rd; logic er;
      idle(3);
      rst_n = 1'b1;
      step();
      // R9 reset state
      rd_chk("R9 reset mask set", slot_a(0, 3), 32'd1);
      rd_chk("R9 reset table zero", slot_a(5, 0), 32'd0);
      chk("R9 reset ctl", {94'd0, fn_enable, fn_maskall}, 96'd0);
      chk("R9 reset out idle", {95'd0, msg_valid}, 96'd0);

      // program slots, still masked
      for (int v = 0; v < NV; v++) begin
         wr(slot_a(v, 0), lo_of(v));
         wr(slot_a(v, 1), hi_of(v));
         wr(slot_a(v, 2), dat_of(v));
      end
      rd_chk("R1 addr lo", slot_a(2, 0), lo_of(2));
      rd_chk("R1 addr hi", slot_a(6, 1), hi_of(6));
      rd_chk("R1 data", slot_a(7, 2), dat_of(7));
      wr(slot_a(3, 3), 32'hFFFF_FFFF);
      rd_chk("R2 only bit0 kept", slot_a(3, 3), 32'd1);
      for (int v = 0; v < NV; v++) wr(slot_a(v, 3), 32'hFFFF_FFFE);
      rd_chk("R2 mask cleared", slot_a(3, 3), 32'd0);

      // R13 latency and R7 content
      push_exp(1);
      step();
      irq_pulse = 8'h02;
      step();
      irq_pulse = '0;
      chk("R13 not yet valid", {95'd0, msg_valid}, 96'd0);
      step();
      chk("R13 valid after two edges", {95'd0, msg_valid}, 96'd1);
      idle(3);

      // R5 masked request, R4 pending map, R6 replay by table write
      wr(slot_a(2, 3), 32'd1);
      pulse(8'h04);
      idle(3);
      chk("R5 no message when masked", {95'd0, msg_valid}, 96'd0);
      rd_chk("R4 pending bit 2", 12'h800, 32'h4);
      wr(12'h800, 32'h0);
      rd_chk("R4 pending not writable", 12'h800, 32'h4);
      push_exp(2);
      wr(slot_a(2, 3), 32'd0);
      idle(4);
      rd_chk("R6 pending cleared", 12'h800, 32'h0);

      // R3 mask-all, R6 replay by clearing mask-all
      ctl(1'b1, 1'b1);
      chk("R3 ctl bits", {94'd0, fn_enable, fn_maskall}, 96'd3);
      pulse(8'h01);
      idle(3);
      rd_chk("R3 mask-all holds vector 0", 12'h800, 32'h1);
      push_exp(0);
      ctl(1'b1, 1'b0);
      idle(4);
      rd_chk("R6 pending cleared after mask-all", 12'h800, 32'h0);

      // R8 ignored requests
      ctl(1'b1, 1'b1);
      num_entries = 6'd2;
      pulse(8'h08);
      idle(2);
      rd_chk("R8 beyond entry count", 12'h800, 32'h0);
      num_entries = 6'd8;
      vec_used = 8'hEF;
      pulse(8'h10);
      idle(2);
      rd_chk("R8 unused vector", 12'h800, 32'h0);
      vec_used = '1;

      // R11 unuse clears pending
      pulse(8'h02);
      idle(2);
      rd_chk("R11 pending before unuse", 12'h800, 32'h2);
      step();
      vec_used = 8'hFD;
      idle(2);
      rd_chk("R11 pending cleared by unuse", 12'h800, 32'h0);
      vec_used = '1;
      ctl(1'b1, 1'b0);
      idle(4);
      chk("R11 nothing replayed", {95'd0, msg_valid}, 96'd0);

      // R10 narrow access rejected, low address bits ignored
      acc(1'b1, slot_a(0, 0), 32'hDEAD_BEEF, 4'h1, rd, er);
      chk("R10 narrow write err", {95'd0, er}, 96'd1);
      acc(1'b0, slot_a(0, 0), 32'd0, 4'h3, rd, er);
      chk("R10 narrow read zero", {64'd0, rd}, 96'd0);
      rd_chk("R10 low bits ignored, no write", slot_a(0, 0) + 12'd2, lo_of(0));

      // R12 stall, hold, ascending drain
      step();
      msg_ready = 1'b0;
      push_exp(0); push_exp(2); push_exp(3);
      pulse(8'h0D);
      idle(4);
      chk("R12 held first", {95'd0, msg_valid}, 96'd1);
      chk("R12 held data", {64'd0, msg_data}, {64'd0, dat_of(0)});
      step();
      msg_ready = 1'b1;
      idle(6);

      // R9 bring-up
      ctl(1'b1, 1'b1);
      step();
      bring_up = 1'b1;
      step();
      bring_up = 1'b0;
      rd_chk("R9 bring-up mask", slot_a(1, 3), 32'd1);
      rd_chk("R9 bring-up zero", slot_a(1, 0), 32'd0);
      chk("R9 bring-up ctl", {94'd0, fn_enable, fn_maskall}, 96'd0);

      idle(4);
      chk("R12 scoreboard drained", 96'(expq.size()), 96'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule